// File: doc/BRIEF.md
# Flash Buffer Read-Location Sequencer

This block keeps one codeword in a local byte buffer and copies chosen slices of it to an output byte stream. Software programs up to four read-location descriptors through a small register bus. Each descriptor holds a start offset, a byte count and a flag that marks the final request. A fill port loads the buffer and then declares it full. A start pulse then makes the sequencer visit the descriptors from index 0 upward. It streams each slice under valid/ready flow control and stops after the descriptor that carries the final flag. At that point the buffer counts as empty and a one-cycle done pulse is raised.

Typical programs are a single whole-buffer request at offset 0, a spare-area-only request whose offset equals the data length, and four back-to-back slices (data, spare, data, spare) where each offset is the sum of the previous offset and size. A slice that would run past the end of the buffer is cut at the boundary and flagged. A program that has no final flag stops after index 3 and is flagged as an error.

Top module: `flash_gather`

## Requirements
- R1: Descriptor i (i = 0..3) is a 32-bit register at byte address 0xF20 + 4*i. It reads back exactly the value last written to it, and all four reset to 0. A read of any other address returns 0, and a write to any other address changes no descriptor.
- R2: Descriptor encoding: start offset in bits [15:0], byte count in bits [30:16], final flag in bit 31. A slice emits buffer bytes offset, offset+1, ... in that order.
- R3: After an accepted start, descriptors are processed in ascending index order. Their slices are concatenated on the output. No descriptor after the first one with the final flag set is used.
- R4: A descriptor with a byte count of zero emits no bytes, but its final flag still ends the sequence.
- R5: If none of descriptors 0..3 carries the final flag, the sequence ends after descriptor 3 and `err_nolast` is 1. Otherwise `err_nolast` is 0 after the sequence. Both error flags are cleared by an accepted start.
- R6: If offset + count exceeds the buffer size (1024 bytes by default), only the bytes below the buffer end are emitted and `err_ovf` is set. It stays set until the next accepted start.
- R7: An output byte is consumed only in a cycle where `out_valid` and `out_ready` are both 1. While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_data` stays unchanged.
- R8: `done` is a single-cycle pulse when the sequence ends. In that same cycle `buf_full` and `busy` drop to 0. A start is accepted only when the block is idle and `buf_full` is 1. A start in any other case has no effect.
- R9: `fill_done` sets `buf_full` only while idle. Fill writes change the buffer only while idle. Fill writes and `fill_done` are ignored while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from reg_addr) |
| fill_we | input | 1 | Buffer byte write strobe |
| fill_addr | input | 10 | Buffer byte address |
| fill_data | input | 8 | Buffer byte write data |
| fill_done | input | 1 | Marks the buffer as full |
| start | input | 1 | Start pulse |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Output sink ready |
| out_data | output | 8 | Output byte |
| busy | output | 1 | Sequence in progress |
| buf_full | output | 1 | Buffer holds an unread codeword |
| done | output | 1 | One-cycle pulse at the end of a sequence |
| err_nolast | output | 1 | Sequence ended without a final flag |
| err_ovf | output | 1 | A slice was clipped at the buffer end |

## Verification
The assertions assume that the descriptor registers are not rewritten while a sequence runs, because the sequencer reads them live. The stimulus writes descriptors only between sequences. The assertions also assume that reset is held long enough to clear the control state. Inside that envelope, the stimulus draws random offsets that sometimes point past the buffer end, random counts that include zero, and random final-flag positions. It also asserts starts and fill writes on purpose during a running sequence, and leaves the buffer empty before a start, to show that those inputs have no effect.

// File: rtl/flash_gather.sv
module flash_gather #(
  parameter int BUF_BYTES = 1024,
  parameter int ADDR_W = 12,
  parameter logic [11:0] BASE_ADDR = 12'hF20
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         reg_we,
  input  logic [ADDR_W-1:0]            reg_addr,
  input  logic [31:0]                  reg_wdata,
  output logic [31:0]                  reg_rdata,
  input  logic                         fill_we,
  input  logic [$clog2(BUF_BYTES)-1:0] fill_addr,
  input  logic [7:0]                   fill_data,
  input  logic                         fill_done,
  input  logic                         start,
  output logic                         out_valid,
  input  logic                         out_ready,
  output logic [7:0]                   out_data,
  output logic                         busy,
  output logic                         buf_full,
  output logic                         done,
  output logic                         err_nolast,
  output logic                         err_ovf
);
  localparam int BA = $clog2(BUF_BYTES);
  localparam int OFF_W = 16;
  localparam int SZ_W = 15;
  localparam int NDESC = 4;
  localparam logic [OFF_W:0] BUF_END = (OFF_W+1)'(BUF_BYTES);

  typedef enum logic [1:0] {S_IDLE, S_LOAD, S_STREAM} state_t;
  state_t state;

  logic [31:0] desc [NDESC];
  logic [7:0]  mem [BUF_BYTES];
  logic [1:0]  idx;
  logic [BA-1:0] pos;
  logic [SZ_W-1:0] rem;

  logic hit;
  logic [1:0] sel;
  assign hit = (reg_addr[ADDR_W-1:4] == BASE_ADDR[ADDR_W-1:4]) && (reg_addr[1:0] == 2'b00);
  assign sel = reg_addr[3:2];
  assign reg_rdata = hit ? desc[sel] : 32'd0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NDESC; i++) desc[i] <= '0;
    end else if (reg_we && hit) begin
      desc[sel] <= reg_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_we && !busy) mem[fill_addr] <= fill_data;
  end

  logic [31:0] cur;
  logic [OFF_W-1:0] cur_off;
  logic [SZ_W-1:0] cur_sz, cur_len;
  logic cur_last, cur_ovf, final_desc;
  logic [OFF_W:0] end_sum, avail;

  assign cur        = desc[idx];
  assign cur_off    = cur[15:0];
  assign cur_sz     = cur[30:16];
  assign cur_last   = cur[31];
  assign end_sum    = {1'b0, cur_off} + {2'b00, cur_sz};
  assign cur_ovf    = end_sum > BUF_END;
  assign avail      = ({1'b0, cur_off} >= BUF_END) ? '0 : BUF_END - {1'b0, cur_off};
  assign cur_len    = cur_ovf ? avail[SZ_W-1:0] : cur_sz;
  assign final_desc = cur_last || (idx == 2'(NDESC-1));

  assign busy      = (state != S_IDLE);
  assign out_valid = (state == S_STREAM);
  assign out_data  = mem[pos];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      idx        <= '0;
      pos        <= '0;
      rem        <= '0;
      done       <= 1'b0;
      buf_full   <= 1'b0;
      err_nolast <= 1'b0;
      err_ovf    <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: begin
          if (fill_done) buf_full <= 1'b1;
          if (start && buf_full) begin
            state      <= S_LOAD;
            idx        <= '0;
            err_nolast <= 1'b0;
            err_ovf    <= 1'b0;
          end
        end
        S_LOAD: begin
          if (cur_ovf) err_ovf <= 1'b1;
          if (cur_len == '0) begin
            if (final_desc) begin
              state      <= S_IDLE;
              done       <= 1'b1;
              buf_full   <= 1'b0;
              err_nolast <= !cur_last;
            end else begin
              idx <= idx + 2'd1;
            end
          end else begin
            pos   <= cur_off[BA-1:0];
            rem   <= cur_len;
            state <= S_STREAM;
          end
        end
        S_STREAM: begin
          if (out_ready) begin
            pos <= pos + BA'(1);
            rem <= rem - SZ_W'(1);
            if (rem == SZ_W'(1)) begin
              if (final_desc) begin
                state      <= S_IDLE;
                done       <= 1'b1;
                buf_full   <= 1'b0;
                err_nolast <= !cur_last;
              end else begin
                idx   <= idx + 2'd1;
                state <= S_LOAD;
              end
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  AST_VALID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data)); // R7
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8
  AST_DONE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !buf_full && !busy); // R8
  AST_BUSY_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> buf_full); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !out_valid); // R3
  AST_STREAM_LEFT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> rem != '0); // R6
  AST_NOLAST_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_nolast) |-> done); // R5
endmodule

// File: tb/flash_gather_tb.sv
module flash_gather_tb;
  localparam int BUFB = 1024;
  localparam logic [11:0] BASE = 12'hF20;

  logic clk = 0, rst_n = 0;
  logic reg_we = 0;
  logic [11:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic fill_we = 0, fill_done = 0, start = 0, out_ready = 0;
  logic [9:0] fill_addr = 0;
  logic [7:0] fill_data = 0, out_data;
  logic out_valid, busy, buf_full, done, err_nolast, err_ovf;

  int checks = 0, failures = 0;
  logic [7:0] mem_m [BUFB];
  logic [31:0] d_m [4];
  logic [7:0] exp_q[$], got_q[$];
  bit exp_ovf, exp_nl;

  always #2 clk = ~clk;

  flash_gather u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .fill_we(fill_we),
    .fill_addr(fill_addr), .fill_data(fill_data), .fill_done(fill_done),
    .start(start), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .busy(busy), .buf_full(buf_full), .done(done),
    .err_nolast(err_nolast), .err_ovf(err_ovf));

  task automatic chk(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic reg_wr(logic [11:0] a, logic [31:0] v);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = v;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic reg_rd(logic [11:0] a, output logic [31:0] v);
    @(negedge clk); reg_addr = a; #1 v = reg_rdata;
  endtask

  task automatic set_desc(int i, int off, int sz, bit last);
    logic [31:0] v;
    v = {last, 15'(sz), 16'(off)};
    d_m[i] = v;
    reg_wr(BASE + 12'(4*i), v);
  endtask

  task automatic refill(int n);
    for (int k = 0; k < n; k++) begin
      int a;
      logic [7:0] v;
      a = (n == BUFB) ? k : int'($urandom % BUFB);
      v = 8'($urandom);
      @(negedge clk); fill_we = 1; fill_addr = 10'(a); fill_data = v;
      mem_m[a] = v;
    end
    @(negedge clk); fill_we = 0; fill_done = 1;
    @(negedge clk); fill_done = 0;
  endtask

  task automatic build_exp();
    exp_q.delete(); exp_ovf = 0; exp_nl = 0;
    for (int i = 0; i < 4; i++) begin
      int off, sz, len;
      bit last;
      off = int'(d_m[i][15:0]); sz = int'(d_m[i][30:16]); last = d_m[i][31];
      len = sz;
      if (off + sz > BUFB) begin
        exp_ovf = 1;
        len = (off >= BUFB) ? 0 : BUFB - off;
      end
      for (int k = 0; k < len; k++) exp_q.push_back(mem_m[off + k]);
      if (last) break;
      if (i == 3) exp_nl = 1;
    end
  endtask

  task automatic run_seq(string tag, bit disturb);
    bit seen_done, hold_bad, pv, pr;
    logic [7:0] pd;
    build_exp();
    got_q.delete(); seen_done = 0; hold_bad = 0; pv = 0; pr = 0; pd = 0;
    @(negedge clk); start = 1;
    for (int cyc = 0; cyc < 20000 && !seen_done; cyc++) begin
      bit rdy;
      @(negedge clk);
      start = 0; fill_we = 0;
      if (disturb && cyc == 3) begin
        start = 1; fill_we = 1; fill_addr = d_m[0][9:0]; fill_data = ~mem_m[d_m[0][9:0]];
      end
      if (pv && !pr && !(out_valid && out_data == pd)) hold_bad = 1;
      rdy = ($urandom % 4) != 0;
      out_ready = rdy;
      if (out_valid && rdy) got_q.push_back(out_data);
      pv = out_valid; pr = rdy; pd = out_data;
      if (done) seen_done = 1;
    end
    start = 0; fill_we = 0;
    chk(seen_done, {tag, " R8 done seen"}, seen_done, 1);
    chk(!buf_full && !busy, {tag, " R8 empty at done"}, {buf_full, busy}, 0);
    chk(!hold_bad, {tag, " R7 valid/data hold"}, hold_bad, 0);
    chk(got_q.size() == exp_q.size(), {tag, " R3 byte count"}, got_q.size(), exp_q.size());
    if (got_q.size() == exp_q.size())
      for (int k = 0; k < exp_q.size(); k++)
        if (got_q[k] !== exp_q[k]) begin
          chk(0, {tag, " R2 byte value"}, got_q[k], exp_q[k]);
          break;
        end
    chk(err_ovf == exp_ovf, {tag, " R6 err_ovf"}, err_ovf, exp_ovf);
    chk(err_nolast == exp_nl, {tag, " R5 err_nolast"}, err_nolast, exp_nl);
    @(negedge clk);
    chk(!done, {tag, " R8 done one cycle"}, done, 0);
  endtask

  initial begin
    #(4 * 190000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd77));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!busy && !out_valid && !done && !buf_full && !err_ovf && !err_nolast,
        "R8 reset state", {busy, out_valid, done, buf_full}, 0);
    reg_rd(BASE, v); chk(v == 0, "R1 reset descriptor", v, 0);

    for (int i = 0; i < 4; i++) begin
      logic [31:0] w;
      w = $urandom;
      reg_wr(BASE + 12'(4*i), w);
      reg_rd(BASE + 12'(4*i), v);
      chk(v == w, "R1 readback", v, w);
    end
    reg_wr(12'hF30, 32'hDEADBEEF);
    reg_rd(12'hF30, v); chk(v == 0, "R1 unmapped read", v, 0);
    reg_rd(12'hF22, v); chk(v == 0, "R1 unaligned read", v, 0);
    for (int i = 0; i < 4; i++) d_m[i] = 0;

    refill(BUFB);
    chk(buf_full, "R9 fill_done sets full", buf_full, 1);

    set_desc(0, 5, 3, 1);
    run_seq("R2 short slice", 0);

    @(negedge clk); start = 1; @(negedge clk); start = 0;
    repeat (4) @(negedge clk);
    chk(!busy && !out_valid, "R8 start ignored when empty", busy, 0);

    refill(4);
    set_desc(0, 0, 512, 1);
    run_seq("R3 whole 512", 0);

    refill(4);
    set_desc(0, 0, 100, 0); set_desc(1, 100, 12, 0);
    set_desc(2, 112, 100, 0); set_desc(3, 212, 12, 1);
    run_seq("R3 four contiguous", 1);

    refill(4);
    set_desc(0, 512, 16, 1);
    run_seq("R3 spare only", 0);

    refill(4);
    set_desc(0, 20, 10, 0); set_desc(1, 0, 0, 1); set_desc(2, 40, 10, 1);
    run_seq("R4 zero size last", 0);

    refill(4);
    set_desc(0, 0, 4, 0); set_desc(1, 8, 0, 0); set_desc(2, 30, 5, 0); set_desc(3, 60, 6, 0);
    run_seq("R5 no last", 0);

    refill(4);
    set_desc(0, 1000, 100, 1);
    run_seq("R6 clip", 0);

    refill(4);
    set_desc(0, 1100, 5, 0); set_desc(1, 0, 3, 1);
    run_seq("R6 past end", 0);

    for (int n = 0; n < 20; n++) begin
      int off;
      off = 0;
      refill(16);
      for (int i = 0; i < 4; i++) begin
        int sz;
        sz = int'($urandom % 200);
        if ($urandom % 5 == 0) off = int'($urandom % 1100);
        set_desc(i, off, sz, ($urandom % 3) == 0);
        off += sz;
      end
      run_seq("R3 random", n % 4 == 0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule